// File: doc/BRIEF.md
# Burst Serial Master with Inter-Byte Gap

This block is a clocked serial master that moves a run of bytes without help from software. Software first fills a 32-byte local buffer through a 16-bit host port. Each 16-bit word can also be written one half at a time. Software then programs a byte count and a gap length, and writes the start bit. The engine fetches each byte from the buffer and shifts it out most significant bit first. It shifts the returning byte in at the same time and stores it over the location the outgoing byte came from.

Between bytes the engine holds the serial clock idle for a programmed number of serial clock periods. The same gap also follows the final byte. Only when that last gap has run out does the block clear its busy flag and pulse its interrupt. The serial clock rate is set by an external tick pulse. Two ticks make one serial clock period.

Top module: `serial_burst_master`

## Requirements
- R1: After reset the gap and count registers read 0x00, the serial clock output is high, busy is 0 and the interrupt is 0.
- R2: Configuration select 0 is the gap register (6 bits, bits 7:6 read 0). Select 1 is the count register (5 bits, bits 7:5 read 0). Select 2 is control: writing bit 0 = 1 starts, bit 1 picks burst mode (1) or single-byte mode (0), and a read returns busy in bit 7 and the mode in bit 1. Select 3 reads 0.
- R3: Writes to the gap, count and control registers are ignored while busy is 1.
- R4: A start sets busy on the next clock edge. A start while busy is ignored and does not lengthen or restart the transfer.
- R5: The serial clock idles high. Each tick moves it one half period: the output bit changes on the falling half and the input is sampled on the rising half, most significant bit first.
- R6: Bytes are moved in ascending index order from index 0. Byte index k lives in word k/2, in bits 7:0 when k is even and in bits 15:8 when k is odd.
- R7: Each received byte overwrites the buffer byte it replaced. Buffer bytes at or beyond the byte count are left unchanged.
- R8: Burst mode moves as many bytes as the count register holds, and a count of 0 moves 32 bytes. Single-byte mode moves exactly one byte whatever the count.
- R9: With gap value G, the first falling edge of the next byte comes 2G+1 ticks after the last rising edge of the byte before. With ticks every 2 clocks this is 4G+2 clocks.
- R10: The interrupt is a one-clock pulse, given once per transfer, in the same cycle that busy drops. With ticks every 2 clocks it comes 4G+1 clocks after the final rising edge.
- R11: The host buffer port reads a whole word at once. Writes obey two per-half byte enables (bit 0 for bits 7:0, bit 1 for bits 15:8) and are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle pulse; each pulse advances the serial clock half a period |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration register select |
| cfgWdata | input | 8 | Configuration write data |
| cfgRdata | output | 8 | Configuration read data (combinational) |
| bufWe | input | 1 | Buffer write strobe |
| bufAddr | input | 4 | Buffer word address |
| bufByteEn | input | 2 | Buffer half enables |
| bufWdata | input | 16 | Buffer write data |
| bufRdata | output | 16 | Buffer read data (combinational) |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to reach is a host that tries to change things in the middle of a burst. The bench first waits until the serial edge counter shows the second byte is under way. It then writes a new gap, a new count, a second start and a buffer word in the same window. After the burst ends it checks four things: the edge count, that there was a single interrupt, the register readbacks and the untouched buffer word. Gap timing is checked by timestamping every serial clock edge and comparing each byte boundary against 4G+2 clocks, for G of 0 and of larger values.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // fetch buffer byte at engIdx into shifter
    logic fallEdge;  // drive sck low, present next bit
    logic riseEdge;  // drive sck high, sample input
    logic store;     // write completed byte back at engIdx
  } dpStrobe_t;
endpackage

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
  import sbm_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  parameter int IVL_W     = 6,
  localparam int IDX_W    = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [7:0]       cfgWdata,
  output logic [7:0]       cfgRdata,
  output logic             busy,
  output logic             irq,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] engIdx
);
  engState_t        state;
  logic [IVL_W-1:0] ivlReg;
  logic [IDX_W-1:0] cntReg;
  logic             autoMode;
  logic [IDX_W-1:0] byteIdx;
  logic [2:0]       bitCnt;
  logic             phaseLow;
  logic [IVL_W:0]   gapTicks;

  logic             startReq;
  logic             gapDone;
  logic             lastByte;
  logic [IDX_W-1:0] lastIdx;
  logic             unusedCfgBits;

  assign unusedCfgBits = ^cfgWdata;

  assign startReq = cfgWe && (cfgSel == 2'd2) && cfgWdata[0] && !busy;
  // count 0 wraps to BUF_BYTES-1 through the subtraction
  assign lastIdx  = autoMode ? (cntReg - 1'b1) : '0;
  assign lastByte = (byteIdx == lastIdx);
  assign gapDone  = (state == ST_GAP) && (gapTicks == {ivlReg, 1'b0});

  always_comb begin
    strobe          = '0;
    strobe.fallEdge = (state == ST_SHIFT) && baudTick && !phaseLow;
    strobe.riseEdge = (state == ST_SHIFT) && baudTick && phaseLow;
    strobe.store    = strobe.riseEdge && (bitCnt == 3'd7);
    strobe.load     = startReq || (gapDone && !lastByte);
    if (startReq)     engIdx = '0;
    else if (gapDone) engIdx = byteIdx + 1'b1;
    else              engIdx = byteIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ivlReg   <= '0;
      cntReg   <= '0;
      autoMode <= 1'b0;
    end else if (cfgWe && !busy) begin
      case (cfgSel)
        2'd0:    ivlReg   <= cfgWdata[IVL_W-1:0];
        2'd1:    cntReg   <= cfgWdata[IDX_W-1:0];
        2'd2:    autoMode <= cfgWdata[1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      irq      <= 1'b0;
      byteIdx  <= '0;
      bitCnt   <= '0;
      phaseLow <= 1'b0;
      gapTicks <= '0;
    end else begin
      irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state    <= ST_SHIFT;
            busy     <= 1'b1;
            byteIdx  <= '0;
            bitCnt   <= '0;
            phaseLow <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (strobe.fallEdge) phaseLow <= 1'b1;
          if (strobe.riseEdge) begin
            phaseLow <= 1'b0;
            bitCnt   <= bitCnt + 1'b1;
            if (bitCnt == 3'd7) begin
              state    <= ST_GAP;
              gapTicks <= '0;
            end
          end
        end
        ST_GAP: begin
          if (gapDone) begin
            if (lastByte) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              irq   <= 1'b1;
            end else begin
              state   <= ST_SHIFT;
              byteIdx <= byteIdx + 1'b1;
              bitCnt  <= '0;
            end
          end else if (baudTick) begin
            gapTicks <= gapTicks + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cfgRdata = '0;
    case (cfgSel)
      2'd0: cfgRdata[IVL_W-1:0] = ivlReg;
      2'd1: cfgRdata[IDX_W-1:0] = cntReg;
      2'd2: begin
        cfgRdata[7] = busy;
        cfgRdata[1] = autoMode;
      end
      default: ;
    endcase
  end

  assert_gap_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> (gapTicks <= {ivlReg, 1'b0}));
  assert_irq_at_finish_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (!busy && $past(busy)));
  assert_busy_drop_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq);
  assert_gap_reg_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(ivlReg) && $stable(cntReg)));
  assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (byteIdx <= lastIdx));
endmodule

// File: rtl/sbm_dpath.sv
module sbm_dpath
  import sbm_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int WORDS    = BUF_BYTES / 2,
  localparam int WADDR_W  = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [IDX_W-1:0]   engIdx,
  input  logic               busy,
  input  logic               bufWe,
  input  logic [WADDR_W-1:0] bufAddr,
  input  logic [1:0]         bufByteEn,
  input  logic [15:0]        bufWdata,
  output logic [15:0]        bufRdata,
  output logic               sck,
  output logic               mosi,
  input  logic               miso
);
  logic [WADDR_W-1:0] engWord;
  logic               engHigh;
  logic [15:0]        engRd;
  logic [7:0]         engByte;
  logic [7:0]         shiftReg;
  logic [7:0]         capByte;

  assign engWord = engIdx[IDX_W-1:1];
  assign engHigh = engIdx[0];
  assign engByte = engHigh ? engRd[15:8] : engRd[7:0];
  assign capByte = {shiftReg[6:0], miso};

  for (genvar h = 0; h < 2; h++) begin : gLane
    logic [7:0] bank [WORDS];
    logic       engWe;
    logic       hostWe;

    assign engWe  = strobe.store && (engHigh == h[0]);
    assign hostWe = bufWe && !busy && bufByteEn[h];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int w = 0; w < WORDS; w++) bank[w] <= '0;
      end else if (engWe) begin
        bank[engWord] <= capByte;
      end else if (hostWe) begin
        bank[bufAddr] <= bufWdata[h*8 +: 8];
      end
    end

    assign bufRdata[h*8 +: 8] = bank[bufAddr];
    assign engRd[h*8 +: 8]    = bank[engWord];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sck      <= 1'b1;
      mosi     <= 1'b1;
    end else begin
      if (strobe.load) shiftReg <= engByte;
      else if (strobe.riseEdge) shiftReg <= capByte;
      if (strobe.fallEdge) begin
        sck  <= 1'b0;
        mosi <= shiftReg[7];
      end else if (strobe.riseEdge) begin
        sck <= 1'b1;
      end
    end
  end

  assert_sck_idle_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sck);
  assert_mosi_held_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));
  assert_store_in_burst_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.store |-> busy);
  assert_load_clock_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> sck);
endmodule

// File: rtl/serial_burst_master.sv
module serial_burst_master #(
  parameter int BUF_BYTES = 32,
  parameter int IVL_W     = 6,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int WADDR_W  = $clog2(BUF_BYTES / 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baudTick,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [7:0]         cfgWdata,
  output logic [7:0]         cfgRdata,
  input  logic               bufWe,
  input  logic [WADDR_W-1:0] bufAddr,
  input  logic [1:0]         bufByteEn,
  input  logic [15:0]        bufWdata,
  output logic [15:0]        bufRdata,
  output logic               busy,
  output logic               irq,
  output logic               sck,
  output logic               mosi,
  input  logic               miso
);
  sbm_pkg::dpStrobe_t strobe;
  logic [IDX_W-1:0]   engIdx;

  sbm_ctrl #(.BUF_BYTES(BUF_BYTES), .IVL_W(IVL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .busy(busy), .irq(irq), .strobe(strobe), .engIdx(engIdx)
  );

  sbm_dpath #(.BUF_BYTES(BUF_BYTES)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .engIdx(engIdx), .busy(busy),
    .bufWe(bufWe), .bufAddr(bufAddr), .bufByteEn(bufByteEn),
    .bufWdata(bufWdata), .bufRdata(bufRdata),
    .sck(sck), .mosi(mosi), .miso(miso)
  );
endmodule

// File: tb/sim_serial_burst_master.sv
module sim_serial_burst_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baudTick = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [7:0]  cfgWdata = '0;
  logic [7:0]  cfgRdata;
  logic        bufWe = 1'b0;
  logic [3:0]  bufAddr = '0;
  logic [1:0]  bufByteEn = '0;
  logic [15:0] bufWdata = '0;
  logic [15:0] bufRdata;
  logic        busy, irq, sck, mosi;
  logic        miso = 1'b1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int riseCnt = 0, fallCnt = 0, irqCnt = 0, irqT = 0;
  int riseT [256];
  int fallT [256];
  logic [7:0] rxB [32];
  logic prevSck = 1'b1;

  serial_burst_master u0 (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .bufWe(bufWe), .bufAddr(bufAddr), .bufByteEn(bufByteEn),
    .bufWdata(bufWdata), .bufRdata(bufRdata),
    .busy(busy), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) baudTick <= ~baudTick;

  function automatic logic [7:0] hostByte(int k, int seed);
    return 8'((k * 13 + seed) & 255);
  endfunction
  function automatic logic [7:0] slvByte(int j);
    return 8'((j * 37 + 90) & 255);
  endfunction

  // serial slave model and edge timestamps
  always @(negedge clk) begin
    logic [7:0] t;
    if (prevSck && !sck && fallCnt < 256) begin
      fallT[fallCnt] = cyc;
      t = slvByte(fallCnt / 8);
      miso = t[7 - (fallCnt % 8)];
      fallCnt++;
    end
    if (!prevSck && sck && riseCnt < 256) begin
      riseT[riseCnt] = cyc;
      rxB[riseCnt / 8][7 - (riseCnt % 8)] = mosi;
      riseCnt++;
    end
    if (irq) begin
      if (irqCnt == 0) irqT = cyc;
      irqCnt++;
    end
    prevSck = sck;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgRead(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    cfgSel = sel;
    #1 d = cfgRdata;
  endtask

  task automatic bufWrite(input int w, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bufWe = 1'b1; bufAddr = 4'(w); bufWdata = d; bufByteEn = be;
    @(negedge clk);
    bufWe = 1'b0;
  endtask

  task automatic bufRead(input int w, output logic [15:0] d);
    @(negedge clk);
    bufAddr = 4'(w);
    #1 d = bufRdata;
  endtask

  task automatic loadBuf(input int seed);
    for (int w = 0; w < 16; w++)
      bufWrite(w, {hostByte(2*w+1, seed), hostByte(2*w, seed)}, 2'b11);
  endtask

  task automatic clearLog();
    riseCnt = 0; fallCnt = 0; irqCnt = 0; irqT = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic verifyBurst(input int n, input int ivl, input int seed);
    logic [15:0] wd;
    bit ok;
    int bad;
    check(riseCnt == 8*n, "R8 rising edge count", riseCnt, 8*n);
    bad = -1;
    for (int j = 0; j < n; j++) if (rxB[j] != hostByte(j, seed)) bad = j;
    check(bad < 0, "R5 R6 transmitted byte order", bad, -1);
    ok = 1;
    for (int k = 0; k < 32; k++) begin
      bufRead(k / 2, wd);
      if ((k % 2 ? wd[15:8] : wd[7:0]) != (k < n ? slvByte(k) : hostByte(k, seed))) ok = 0;
    end
    check(ok, "R7 buffer after transfer", ok, 1);
    bad = -1;
    for (int k = 0; k + 1 < n; k++)
      if (fallT[8*k+8] - riseT[8*k+7] != 4*ivl + 2) bad = fallT[8*k+8] - riseT[8*k+7];
    check(bad < 0, "R9 inter-byte gap", bad, 4*ivl + 2);
    check(irqCnt == 1, "R10 interrupt pulse count", irqCnt, 1);
    check(irqT - riseT[8*n-1] == 4*ivl + 1, "R10 interrupt delay", irqT - riseT[8*n-1], 4*ivl + 1);
    check(!busy && sck, "R5 idle after transfer", {busy, sck}, 1);
  endtask

  task automatic runXfer(input bit burst, input int cnt, input int ivl, input int seed);
    int n;
    n = burst ? (cnt == 0 ? 32 : cnt) : 1;
    loadBuf(seed);
    cfgWrite(2'd0, 8'(ivl));
    cfgWrite(2'd1, 8'(cnt));
    clearLog();
    cfgWrite(2'd2, {6'd0, burst, 1'b1});
    check(busy == 1'b1, "R4 busy after start", busy, 1);
    waitIdle();
    verifyBurst(n, ivl, seed);
  endtask

  task automatic testReset();
    logic [7:0] d;
    cfgRead(2'd0, d); check(d == 8'h00, "R1 gap reset", d, 0);
    cfgRead(2'd1, d); check(d == 8'h00, "R1 count reset", d, 0);
    check(sck && !busy && !irq, "R1 outputs reset", {sck, busy, irq}, 3'b100);
  endtask

  task automatic testRegs();
    logic [7:0] d;
    cfgWrite(2'd0, 8'hFF); cfgRead(2'd0, d); check(d == 8'h3F, "R2 gap width", d, 8'h3F);
    cfgWrite(2'd1, 8'hFF); cfgRead(2'd1, d); check(d == 8'h1F, "R2 count width", d, 8'h1F);
    cfgWrite(2'd2, 8'h02); cfgRead(2'd2, d); check(d == 8'h02, "R2 mode readback", d, 8'h02);
    check(!busy, "R2 mode write does not start", busy, 0);
    cfgRead(2'd3, d); check(d == 8'h00, "R2 unused select", d, 0);
  endtask

  task automatic testHalves();
    logic [15:0] wd;
    loadBuf(7);
    bufWrite(2, 16'hBEEF, 2'b01);
    bufRead(2, wd);
    check(wd == {hostByte(5, 7), 8'hEF}, "R11 low half write", wd, {hostByte(5, 7), 8'hEF});
    bufWrite(2, 16'h1234, 2'b10);
    bufRead(2, wd);
    check(wd == 16'h12EF, "R11 high half write", wd, 16'h12EF);
  endtask

  task automatic testBusyWrites();
    logic [7:0] d;
    logic [15:0] wd;
    int n = 0;
    loadBuf(3);
    cfgWrite(2'd0, 8'd1);
    cfgWrite(2'd1, 8'd6);
    clearLog();
    cfgWrite(2'd2, 8'h03);
    while (riseCnt < 10 && n < 2000) begin @(negedge clk); n++; end
    cfgRead(2'd2, d); check(d[7] == 1'b1, "R4 busy bit readback", d, 8'h82);
    cfgWrite(2'd0, 8'h10);
    cfgWrite(2'd1, 8'h02);
    cfgWrite(2'd2, 8'h01);
    bufWrite(15, 16'hFFFF, 2'b11);
    waitIdle();
    check(riseCnt == 48, "R4 start while busy ignored", riseCnt, 48);
    check(irqCnt == 1, "R4 single interrupt", irqCnt, 1);
    cfgRead(2'd0, d); check(d == 8'd1, "R3 gap write ignored", d, 1);
    cfgRead(2'd1, d); check(d == 8'd6, "R3 count write ignored", d, 6);
    cfgRead(2'd2, d); check(d == 8'h02, "R3 control write ignored", d, 8'h02);
    bufRead(15, wd);
    check(wd == {hostByte(31, 3), hostByte(30, 3)}, "R11 buffer write ignored while busy",
          wd, {hostByte(31, 3), hostByte(30, 3)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testHalves();
    runXfer(1'b1, 5, 3, 11);
    runXfer(1'b1, 3, 0, 21);
    runXfer(1'b0, 4, 2, 31);
    runXfer(1'b1, 0, 0, 41);
    runXfer(1'b1, 2, 63, 51);
    testBusyWrites();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule